// File: doc/BRIEF.md
# GPIO Pin Resolver and Level-Sense Detector

This block resolves, for a bank of general-purpose pins, what each pad sees and what software reads back. Every pin has a 32-bit configuration word that selects the direction, whether the input buffer is connected, an optional pull resistor, a drive mode and a level-sense setting. From these, the output register and an external stimulus per pin (a "driven" flag plus a level), the block computes the pin's input-register bit, the pad output enable and level, a short-circuit warning and one aggregated sense-detect signal.

Each cycle with `eval_en` high is one evaluation. All results are registered, so they appear one clock after the inputs they come from. The input-register bits are state: an undriven, unpulled pin keeps its last value. A change strobe per pin marks pins whose drive state or raw output level differs from the one recorded at the previous evaluation. With `eval_en` low nothing is evaluated and all state holds.

Top module: `gpr_resolver_top`

## Requirements
- R1: During a synchronous active-low reset all outputs and the stored input bits are cleared, and they stay zero on the first cycle after reset ends if no evaluation has yet happened.
- R2: The drive-mode field (config bits [10:8]) connects the driver always for values 0..3, only when the pin's output bit is 1 for values 4..5, and only when it is 0 for values 6..7; `pad_oe` is high only if the driver is connected and the direction bit (config bit 0) is 1, except as R6 states.
- R3: `pad_lvl` follows the resolved output level while `pad_oe` is high and is 0 while `pad_oe` is low (tri-state).
- R4: With config bit 1 set (input buffer disconnected), a pull field (bits [3:2]) of 1 forces the input bit to 0 and a value of 3 forces it to 1; values 0 and 2 mean no pull and leave the input bit unchanged, even if the pin is externally driven.
- R5: With the input buffer connected and the external driven flag high, the input bit takes the external level.
- R6: With the input buffer connected and no external drive, an active pull on a pin whose driver is not connected makes the pin drive the pull level (`pad_oe` high, level = pull level); whenever the pin then drives, the input bit takes the driven level.
- R7: `short_vec` bit i is high while pin i has its input buffer connected, is externally driven, has its own driver connected by R2, and the output bit differs from the external level.
- R8: The sense field (bits [17:16]) gives a match on an external level of 1 for value 2 and of 0 for value 3; a match counts only on an externally driven pin with the input buffer connected, and `detect` is the OR of all matches.
- R9: `chg_strobe` bit i pulses for one evaluation when pin i's drive-enable or raw output level differs from the values recorded at the previous evaluation (both start at 0 after reset).
- R10: While `eval_en` is low, `in_reg`, `pad_oe`, `pad_lvl`, `short_vec` and `detect` hold, and `chg_strobe` is 0.
- R11: Removing the external drive on a connected, unpulled, undriven pin leaves its input bit at the last external level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| eval_en | input | 1 | Evaluate this cycle |
| cfg_words | input | NPIN*32 | Configuration words, pin i at bits [32*i+31:32*i] |
| out_reg | input | NPIN | Output register, one bit per pin |
| ext_drv | input | NPIN | External stimulus present per pin |
| ext_lvl | input | NPIN | External stimulus level per pin |
| in_reg | output | NPIN | Resolved input-register bits |
| pad_oe | output | NPIN | Pad output enable |
| pad_lvl | output | NPIN | Pad output level, 0 when not enabled |
| short_vec | output | NPIN | Short-circuit warning per pin |
| detect | output | 1 | Aggregated level-sense detect |
| chg_strobe | output | NPIN | Drive state or level changed at this evaluation |

## Verification
The bench goes after the drive modes that connect only on one output polarity, where a design that ignores the output bit would enable the pad in the wrong half of the cases, and after the pull override of an undriven input, where a wrong design would leave the pad tri-stated and the input bit stale. It checks that a disconnected input buffer ignores the external level and that withdrawing the external drive keeps the last input value, both of which a design that treats the input bit as purely combinational would get wrong. It checks sense matches only count on externally driven, connected pins, and that the change strobe compares the raw level, so a pin whose level flips while tri-stated still pulses.

// File: rtl/gpr_pkg.sv
// Shared field positions, encodings and the per-pin result record of
// the GPIO pin resolver. Assumes a 32-bit configuration word per pin.
package gpr_pkg;
    localparam int CFG_W      = 32;
    localparam int DIR_BIT    = 0;
    localparam int INDIS_BIT  = 1;
    localparam int PULL_LO    = 2;
    localparam int DRV_LO     = 8;
    localparam int SENSE_LO   = 16;

    typedef enum logic [1:0] {
        PULL_NONE = 2'd0,
        PULL_DOWN = 2'd1,
        PULL_RSVD = 2'd2,
        PULL_UP   = 2'd3
    } pull_e;

    typedef enum logic [1:0] {
        SENSE_OFF  = 2'd0,
        SENSE_RSVD = 2'd1,
        SENSE_HIGH = 2'd2,
        SENSE_LOW  = 2'd3
    } sense_e;

    typedef struct packed {
        logic in_bit;
        logic conn;
        logic lvl;
        logic shorted;
        logic hit;
    } pin_res_t;
endpackage

// File: rtl/gpr_pin_cell.sv
// Combinational resolution of one pin: decides the driver connection,
// the pull override, the next input bit, the short warning and the
// sense match. Assumes in_cur is the stored input bit of this pin.
module gpr_pin_cell
    import gpr_pkg::*;
(
    input  logic [CFG_W-1:0] cfg,
    input  logic             out_bit,
    input  logic             ext_drv,
    input  logic             ext_lvl,
    input  logic             in_cur,
    output pin_res_t         res
);
    logic       mode_ok;
    logic       drv_real;
    logic       has_pull;
    logic       pull_lvl;
    pull_e      pull;
    sense_e     sense;
    logic [2:0] drv_mode;

    // Decode fields and decide whether the driver is connected.
    always_comb begin
        drv_mode = cfg[DRV_LO +: 3];
        pull     = pull_e'(cfg[PULL_LO +: 2]);
        sense    = sense_e'(cfg[SENSE_LO +: 2]);
        case (drv_mode[2:1])
            2'b10:   mode_ok = out_bit;
            2'b11:   mode_ok = !out_bit;
            default: mode_ok = 1'b1;
        endcase
        drv_real = mode_ok && cfg[DIR_BIT];
        has_pull = (pull == PULL_DOWN) || (pull == PULL_UP);
        pull_lvl = (pull == PULL_UP);
    end

    // Resolve input bit, effective drive, short and sense for this pin.
    always_comb begin
        res.conn    = drv_real;
        res.lvl     = out_bit;
        res.in_bit  = in_cur;
        res.shorted = 1'b0;
        res.hit     = 1'b0;
        if (cfg[INDIS_BIT]) begin
            if (has_pull) res.in_bit = pull_lvl;
        end else if (ext_drv) begin
            res.in_bit  = ext_lvl;
            res.shorted = drv_real && (out_bit != ext_lvl);
            res.hit     = ((sense == SENSE_HIGH) && ext_lvl) ||
                          ((sense == SENSE_LOW) && !ext_lvl);
        end else begin
            if (has_pull && !drv_real) begin
                res.conn = 1'b1;
                res.lvl  = pull_lvl;
            end
            if (res.conn) res.in_bit = res.lvl;
        end
    end
endmodule

// File: rtl/gpr_detect_merge.sv
// Merges the per-pin sense matches into one detect level (wired-OR).
// Assumes hits are already qualified by the pin cells.
module gpr_detect_merge #(
    parameter int NPIN = 32
) (
    input  logic [NPIN-1:0] hits,
    output logic            det
);
    // OR-reduce all pin matches.
    always_comb det = |hits;
endmodule

// File: rtl/gpr_resolver_top.sv
// GPIO pin resolver top: one pin cell per pin, the detect merge and the
// evaluation registers, including the recorded drive state used for the
// change strobe. All outputs are registered; eval_en gates every update.
module gpr_resolver_top
    import gpr_pkg::*;
#(
    parameter int NPIN = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  eval_en,
    input  logic [NPIN*CFG_W-1:0] cfg_words,
    input  logic [NPIN-1:0]       out_reg,
    input  logic [NPIN-1:0]       ext_drv,
    input  logic [NPIN-1:0]       ext_lvl,
    output logic [NPIN-1:0]       in_reg,
    output logic [NPIN-1:0]       pad_oe,
    output logic [NPIN-1:0]       pad_lvl,
    output logic [NPIN-1:0]       short_vec,
    output logic                  detect,
    output logic [NPIN-1:0]       chg_strobe
);
    pin_res_t [NPIN-1:0] res;
    logic [NPIN-1:0] in_q, oe_q, lvl_q, short_q, chg_q;
    logic [NPIN-1:0] in_n, conn_n, lvl_n, short_n, hit_n;
    logic            det_q, det_n;

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        gpr_pin_cell u_cell (
            .cfg     (cfg_words[i*CFG_W +: CFG_W]),
            .out_bit (out_reg[i]),
            .ext_drv (ext_drv[i]),
            .ext_lvl (ext_lvl[i]),
            .in_cur  (in_q[i]),
            .res     (res[i])
        );
        assign in_n[i]    = res[i].in_bit;
        assign conn_n[i]  = res[i].conn;
        assign lvl_n[i]   = res[i].lvl;
        assign short_n[i] = res[i].shorted;
        assign hit_n[i]   = res[i].hit;
    end

    gpr_detect_merge #(.NPIN(NPIN)) u_merge (
        .hits (hit_n),
        .det  (det_n)
    );

    // Evaluation registers and change tracking against the recorded state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_q    <= '0;
            oe_q    <= '0;
            lvl_q   <= '0;
            short_q <= '0;
            chg_q   <= '0;
            det_q   <= 1'b0;
        end else if (eval_en) begin
            in_q    <= in_n;
            oe_q    <= conn_n;
            lvl_q   <= lvl_n;
            short_q <= short_n;
            det_q   <= det_n;
            chg_q   <= (conn_n ^ oe_q) | (lvl_n ^ lvl_q);
        end else begin
            chg_q   <= '0;
        end
    end

    assign in_reg     = in_q;
    assign pad_oe     = oe_q;
    assign pad_lvl    = lvl_q & oe_q;
    assign short_vec  = short_q;
    assign detect     = det_q;
    assign chg_strobe = chg_q;
endmodule

// File: rtl/gpr_resolver_chk.sv
// Port-level checker for gpr_resolver_top, attached by bind.
module gpr_resolver_chk #(
    parameter int NPIN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            eval_en,
    input logic [NPIN-1:0] ext_drv,
    input logic [NPIN-1:0] in_reg,
    input logic [NPIN-1:0] pad_oe,
    input logic [NPIN-1:0] pad_lvl,
    input logic [NPIN-1:0] short_vec,
    input logic            detect,
    input logic [NPIN-1:0] chg_strobe
);
    // R3
    tristate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_lvl & ~pad_oe) == '0);
    // R7
    short_needs_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (short_vec & ~pad_oe) == '0);
    // R10
    idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !eval_en |=> chg_strobe == '0);
    // R10
    idle_hold_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !eval_en |=> $stable(in_reg));
    // R8
    detect_needs_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_en && ext_drv == '0) |=> !detect);
endmodule

bind gpr_resolver_top gpr_resolver_chk #(.NPIN(NPIN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .eval_en    (eval_en),
    .ext_drv    (ext_drv),
    .in_reg     (in_reg),
    .pad_oe     (pad_oe),
    .pad_lvl    (pad_lvl),
    .short_vec  (short_vec),
    .detect     (detect),
    .chg_strobe (chg_strobe)
);

// File: tb/tb_gpr_resolver_top.sv
`timescale 1ns/1ps
module tb_gpr_resolver_top;
    localparam int NPIN = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              eval_en = 1'b0;
    logic [NPIN*32-1:0] cfg_words = '0;
    logic [NPIN-1:0]   out_reg = '0, ext_drv = '0, ext_lvl = '0;
    logic [NPIN-1:0]   in_reg, pad_oe, pad_lvl, short_vec, chg_strobe;
    logic              detect;

    int checks = 0, fails = 0;
    bit done = 0;
    int unsigned seed_val;

    // model state
    logic [NPIN-1:0] m_in = '0, m_oe = '0, m_lvl = '0, m_short = '0, m_chg = '0;
    logic            m_det = 1'b0;

    always #2 clk = ~clk;

    gpr_resolver_top #(.NPIN(NPIN)) dut (
        .clk(clk), .rst_n(rst_n), .eval_en(eval_en), .cfg_words(cfg_words),
        .out_reg(out_reg), .ext_drv(ext_drv), .ext_lvl(ext_lvl),
        .in_reg(in_reg), .pad_oe(pad_oe), .pad_lvl(pad_lvl),
        .short_vec(short_vec), .detect(detect), .chg_strobe(chg_strobe)
    );

    function automatic logic [31:0] mkcfg(bit dir, bit indis, int pull, int drv, int sense);
        logic [31:0] c = '0;
        c[0] = dir; c[1] = indis; c[3:2] = pull[1:0];
        c[10:8] = drv[2:0]; c[17:16] = sense[1:0];
        return c;
    endfunction

    task automatic chk(string tag, string nm, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, nm, act, exp);
        end
    endtask

    // Advance one clock with the model computed from the requirements.
    task automatic step(string tag);
        logic [NPIN-1:0] n_in, n_oe, n_lvl, n_sh, n_chg;
        logic n_det;
        n_in = m_in; n_oe = '0; n_lvl = '0; n_sh = '0; n_det = 1'b0;
        for (int i = 0; i < NPIN; i++) begin
            logic [31:0] c;
            bit con, pullon, pv, lv;
            c = cfg_words[i*32 +: 32];
            case (c[10:8])
                3'd4, 3'd5: con = out_reg[i];
                3'd6, 3'd7: con = !out_reg[i];
                default:    con = 1'b1;
            endcase
            con = con && c[0];
            pullon = (c[3:2] == 2'd1) || (c[3:2] == 2'd3);
            pv = (c[3:2] == 2'd3);
            lv = out_reg[i];
            if (c[1]) begin
                if (pullon) n_in[i] = pv;
            end else if (ext_drv[i]) begin
                n_in[i] = ext_lvl[i];
                n_sh[i] = con && (out_reg[i] != ext_lvl[i]);
                if ((c[17:16] == 2'd2 && ext_lvl[i]) || (c[17:16] == 2'd3 && !ext_lvl[i]))
                    n_det = 1'b1;
            end else begin
                if (pullon && !con) begin con = 1'b1; lv = pv; end
                if (con) n_in[i] = lv;
            end
            n_oe[i] = con; n_lvl[i] = lv;
        end
        n_chg = (n_oe ^ m_oe) | (n_lvl ^ m_lvl);
        if (eval_en) begin
            m_in = n_in; m_oe = n_oe; m_lvl = n_lvl; m_short = n_sh;
            m_det = n_det; m_chg = n_chg;
        end else m_chg = '0;
        @(posedge clk);
        @(negedge clk);
        chk(tag == "" ? "R5" : tag, "in_reg", in_reg, m_in);
        chk(tag == "" ? "R2" : tag, "pad_oe", pad_oe, m_oe);
        chk(tag == "" ? "R3" : tag, "pad_lvl", pad_lvl, m_lvl & m_oe);
        chk(tag == "" ? "R7" : tag, "short_vec", short_vec, m_short);
        chk(tag == "" ? "R8" : tag, "detect", {31'b0, detect}, {31'b0, m_det});
        chk(tag == "" ? "R9" : tag, "chg_strobe", chg_strobe, m_chg);
    endtask

    task automatic set_cfg(int p, logic [31:0] c);
        cfg_words[p*32 +: 32] = c;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        seed_val = $urandom(32'h5eed_1234);
        for (int p = 0; p < NPIN; p++) set_cfg(p, 32'h2);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset clears everything
        chk("R1", "in_reg", in_reg, '0);
        chk("R1", "pad_oe", pad_oe, '0);
        chk("R1", "chg_strobe", chg_strobe, '0);
        chk("R1", "detect", {31'b0, detect}, 32'b0);
        rst_n = 1'b1;
        step("R1");
        eval_en = 1'b1;

        // R2: polarity-dependent drive modes on pin 0 and 1
        set_cfg(0, mkcfg(1, 0, 0, 4, 0));
        set_cfg(1, mkcfg(1, 0, 0, 6, 0));
        out_reg = '0;                step("R2");
        out_reg = 32'h3;             step("R2");
        set_cfg(2, mkcfg(0, 0, 0, 2, 0));
        out_reg = 32'h7;             step("R2");

        // R6: pull-up on undriven pin 3 with direction input
        set_cfg(3, mkcfg(0, 0, 3, 0, 0)); step("R6");
        set_cfg(3, mkcfg(0, 0, 1, 0, 0)); step("R6");

        // R5 and R11: external drive then removal on pin 4
        set_cfg(4, mkcfg(0, 0, 0, 0, 0));
        ext_drv[4] = 1'b1; ext_lvl[4] = 1'b1; step("R5");
        ext_drv[4] = 1'b0; ext_lvl[4] = 1'b0; step("R11");
        step("R11");

        // R4: disconnected input buffer, pull-down then no pull on pin 5
        set_cfg(5, mkcfg(0, 1, 1, 0, 0));
        ext_drv[5] = 1'b1; ext_lvl[5] = 1'b1; step("R4");
        set_cfg(5, mkcfg(0, 1, 3, 0, 0)); ext_lvl[5] = 1'b0; step("R4");
        set_cfg(5, mkcfg(0, 1, 2, 0, 0)); step("R4");

        // R7: conflicting internal and external drive on pin 6
        set_cfg(6, mkcfg(1, 0, 0, 0, 0)); out_reg[6] = 1'b1;
        ext_drv[6] = 1'b1; ext_lvl[6] = 1'b0; step("R7");
        ext_lvl[6] = 1'b1; step("R7");

        // R8: sense low and high on pin 7, and on disconnected buffer
        set_cfg(7, mkcfg(0, 0, 0, 0, 3)); ext_drv[7] = 1'b1; ext_lvl[7] = 1'b0; step("R8");
        set_cfg(7, mkcfg(0, 0, 0, 0, 2)); step("R8");
        ext_lvl[7] = 1'b1; step("R8");
        set_cfg(7, mkcfg(0, 1, 0, 0, 2)); step("R8");

        // R9: level flip while tri-stated still strobes
        set_cfg(8, mkcfg(0, 0, 0, 0, 0)); out_reg[8] = 1'b0; step("R9");
        out_reg[8] = 1'b1; step("R9");

        // R10: eval_en low holds state while inputs change
        eval_en = 1'b0;
        ext_lvl = ~ext_lvl; out_reg = ~out_reg; step("R10");
        step("R10");
        eval_en = 1'b1;

        // Random stimulus
        for (int n = 0; n < 3000; n++) begin
            for (int p = 0; p < NPIN; p++) set_cfg(p, $urandom());
            out_reg = $urandom();
            ext_drv = $urandom();
            ext_lvl = $urandom();
            eval_en = ($urandom() % 8) != 0;
            step("");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule